// File: doc/BRIEF.md
# One-Wire Device ID Search Walker

This block enumerates the 64-bit identifiers of all devices sharing a one-wire bus. It walks the binary search tree. For each identifier bit it reads the wired-AND of the bit and of its complement from every device still taking part, and so learns whether all remaining devices agree. It then writes one chosen direction back, which drops every device that does not match. Where both values exist (a discrepancy), the choice is steered by a compact branch mask. Its bits are indexed by the order in which discrepancies occur, not by identifier bit position. Each pass therefore ends on a new device, and the next pass takes the other side of the deepest branch that was resolved towards 0.

The block drives a slot engine through a level request (`slot_req` with an operation code, held until `slot_done`). It writes each identifier into an external memory, one byte at a time. A search is started by a one-cycle `start`. It ends with a one-cycle `done`, an error code and the number of identifiers stored.

The controller has six states:
- `S_IDLE` waits for `start` and goes to `S_RESET`.
- `S_RESET` issues a bus reset. With a presence response it goes to `S_CMD`. Without one it returns to `S_IDLE`.
- `S_CMD` issues eight write slots and then goes to `S_RD_T`.
- `S_RD_T` reads the true bit and goes to `S_RD_C`.
- `S_RD_C` reads the complement bit. It then goes to `S_WRITE`, or returns to `S_IDLE` on an error.
- `S_WRITE` writes the chosen bit. It then goes back to `S_RD_T`. After bit 63 it goes to `S_RESET` for another pass, or to `S_IDLE` when the search is over.

Top module: `ow_srch_walker`

## Requirements
- R1: Every pass starts with a reset slot (op 0). If `slot_rbit` is 0 at the end of that slot (no presence), the search ends with `err_code` 1 and no identifier is written.
- R2: After the reset, the search command 0xF0 is sent as eight write slots (op 1), least significant bit first.
- R3: For each of the 64 identifier bits the block issues exactly: a read slot (op 2) for the true bit, a read slot for the complement bit, then one write slot carrying the chosen bit.
- R4: When the true and complement reads differ, the bit written equals the true bit.
- R5: When both reads return 1, the search ends at once with `err_code` 2.
- R6: At a discrepancy (both reads 0), the block takes 0 unless this discrepancy's branch-mask bit is set, in which case it takes 1. Each pass reaches a different device, and the identifiers are found in ascending order of their bit-reversed value.
- R7: Identifier k is written as 8 bytes at addresses 8k to 8k+7. Byte b holds identifier bits 8b+7..8b, with bit 0 of the bus order in byte 0, bit 0.
- R8: A new pass starts only while an untaken branch remains and fewer than MAX_IDS identifiers are stored. `found_count` never exceeds MAX_IDS, and the search ends with `err_code` 0.
- R9: A discrepancy beyond the PATH_W-th in one pass ends the search with `err_code` 3.
- R10: `start` has no effect while `busy` is high. No extra reset slot is issued and the stored count is kept.
- R11: After reset, `busy`, `done`, `slot_req`, `id_we` and `found_count` are 0. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| busy | output | 1 | High while a search runs |
| done | output | 1 | One-cycle pulse at the end of a search |
| err_code | output | 2 | 0 none, 1 no presence, 2 both reads 1, 3 branch mask exhausted |
| found_count | output | $clog2(MAX_IDS+1) | Number of identifiers stored |
| slot_req | output | 1 | Slot request, held until `slot_done` |
| slot_op | output | 2 | 0 reset, 1 write, 2 read |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | One-cycle slot completion |
| slot_rbit | input | 1 | Read bit, or presence after a reset slot |
| id_we | output | 1 | Identifier memory write enable |
| id_addr | output | $clog2(MAX_IDS*8) | Identifier memory byte address |
| id_wdata | output | 8 | Identifier byte |

## Verification
The write of an identifier's last byte and the end of the search fall in the same cycle. In that cycle `id_we` and `done` are high together, and `found_count` steps. Every search that ends after a completed pass provokes this, including a search capped at MAX_IDS. The bench captures every write strobe on its own, and compares the memory only after the `done` cycle has passed, so a lost or misaddressed final byte shows up as a wrong identifier. A `start` raised mid-search is judged by counting the reset slots against the number of passes.

// File: rtl/ow_srch_pkg.sv
package ow_srch_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RESET, S_CMD, S_RD_T, S_RD_C, S_WRITE
    } walk_state_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2
    } slot_op_t;

    typedef enum logic [1:0] {
        E_NONE = 2'd0, E_NO_PRESENCE = 2'd1, E_BOTH_ONES = 2'd2, E_DEPTH = 2'd3
    } walk_err_t;

    localparam int ID_BITS = 64;
endpackage

// File: rtl/ow_srch_branch.sv
module ow_srch_branch #(
    parameter int PATH_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic search_init,
    input  logic pass_init,
    input  logic disc_ev,
    input  logic commit,
    output logic take_one,
    output logic depth_ovf,
    output logic next_nz
);
    localparam logic [PATH_W-1:0] ONE = PATH_W'(1);

    logic [PATH_W-1:0] path_q, next_q, pos_q;

    assign take_one  = |(pos_q & path_q);
    assign depth_ovf = (pos_q == '0);
    assign next_nz   = |next_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= '0;
            next_q <= '0;
            pos_q  <= ONE;
        end else begin
            if (search_init)
                path_q <= '0;
            else if (commit)
                path_q <= next_q;

            if (search_init || pass_init) begin
                next_q <= '0;
                pos_q  <= ONE;
            end else if (disc_ev) begin
                if (!take_one)
                    next_q <= (path_q & (pos_q - ONE)) | pos_q;
                pos_q <= pos_q << 1;
            end
        end
    end

    // R9: the controller never resolves a discrepancy once the mask is used up
    a_r9_no_disc_past_mask: assert property (@(posedge clk) disable iff (!rst_n)
        disc_ev |-> !depth_ovf);
    // R6: at most one position pointer bit
    a_r6_pos_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pos_q));
endmodule

// File: rtl/ow_srch_idasm.sv
module ow_srch_idasm #(
    parameter int MAX_IDS = 4,
    parameter int CNT_W   = $clog2(MAX_IDS + 1),
    parameter int ADDR_W  = $clog2(MAX_IDS * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_ev,
    input  logic              bit_val,
    output logic              last_bit,
    output logic [CNT_W-1:0]  count,
    output logic              id_we,
    output logic [ADDR_W-1:0] id_addr,
    output logic [7:0]        id_wdata
);
    logic [5:0]        bit_idx_q;
    logic [6:0]        sh_q;
    logic [CNT_W-1:0]  count_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;

    assign last_bit = (bit_idx_q == 6'd63);
    assign count    = count_q;
    assign id_we    = we_q;
    assign id_addr  = addr_q;
    assign id_wdata = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            sh_q      <= '0;
            count_q   <= '0;
            we_q      <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            we_q <= 1'b0;
            if (clear) begin
                bit_idx_q <= '0;
                count_q   <= '0;
            end else if (bit_ev) begin
                bit_idx_q <= bit_idx_q + 6'd1;
                sh_q      <= {bit_val, sh_q[6:1]};
                if (bit_idx_q[2:0] == 3'd7) begin
                    we_q   <= 1'b1;
                    data_q <= {bit_val, sh_q};
                    addr_q <= ADDR_W'(count_q) * ADDR_W'(8) + ADDR_W'(bit_idx_q[5:3]);
                end
                if (bit_idx_q == 6'd63)
                    count_q <= count_q + CNT_W'(1);
            end
        end
    end

    a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count_q) <= MAX_IDS);
    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (32'(addr_q) < MAX_IDS * 8));
endmodule

// File: rtl/ow_srch_walker.sv
module ow_srch_walker
    import ow_srch_pkg::*;
#(
    parameter int         MAX_IDS  = 4,
    parameter int         PATH_W   = 32,
    parameter logic [7:0] CMD_CODE = 8'hF0,
    localparam int        CNT_W    = $clog2(MAX_IDS + 1),
    localparam int        ADDR_W   = $clog2(MAX_IDS * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [CNT_W-1:0]  found_count,
    output logic              slot_req,
    output logic [1:0]        slot_op,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit,
    output logic              id_we,
    output logic [ADDR_W-1:0] id_addr,
    output logic [7:0]        id_wdata
);
    walk_state_t state_q, state_d;
    walk_err_t   err_q, err_d;
    logic [2:0]  cmd_idx_q;
    logic        tbit_q, chosen_q, chosen_d, done_q;
    logic        search_init, pass_init, disc_ev, commit, bit_ev, fin;
    logic        take_one, depth_ovf, next_nz, last_bit;

    ow_srch_branch #(.PATH_W(PATH_W)) u_branch (
        .clk(clk), .rst_n(rst_n), .search_init(search_init), .pass_init(pass_init),
        .disc_ev(disc_ev), .commit(commit), .take_one(take_one),
        .depth_ovf(depth_ovf), .next_nz(next_nz)
    );

    ow_srch_idasm #(.MAX_IDS(MAX_IDS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_idasm (
        .clk(clk), .rst_n(rst_n), .clear(search_init), .bit_ev(bit_ev),
        .bit_val(chosen_q), .last_bit(last_bit), .count(found_count),
        .id_we(id_we), .id_addr(id_addr), .id_wdata(id_wdata)
    );

    // next state and control strobes
    always_comb begin
        state_d     = state_q;
        err_d       = E_NONE;
        chosen_d    = chosen_q;
        search_init = 1'b0;
        pass_init   = 1'b0;
        disc_ev     = 1'b0;
        commit      = 1'b0;
        bit_ev      = 1'b0;
        fin         = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                search_init = 1'b1;
                state_d     = S_RESET;
            end
            S_RESET: if (slot_done) begin
                if (slot_rbit) begin
                    state_d = S_CMD;
                end else begin
                    fin     = 1'b1;
                    err_d   = E_NO_PRESENCE;
                    state_d = S_IDLE;
                end
            end
            S_CMD: if (slot_done && cmd_idx_q == 3'd7) state_d = S_RD_T;
            S_RD_T: if (slot_done) state_d = S_RD_C;
            S_RD_C: if (slot_done) begin
                if (tbit_q && slot_rbit) begin
                    fin     = 1'b1;
                    err_d   = E_BOTH_ONES;
                    state_d = S_IDLE;
                end else if (!tbit_q && !slot_rbit) begin
                    if (depth_ovf) begin
                        fin     = 1'b1;
                        err_d   = E_DEPTH;
                        state_d = S_IDLE;
                    end else begin
                        disc_ev  = 1'b1;
                        chosen_d = take_one;
                        state_d  = S_WRITE;
                    end
                end else begin
                    chosen_d = tbit_q;
                    state_d  = S_WRITE;
                end
            end
            S_WRITE: if (slot_done) begin
                bit_ev = 1'b1;
                if (!last_bit) begin
                    state_d = S_RD_T;
                end else if (next_nz && (32'(found_count) + 32'd1 < 32'(MAX_IDS))) begin
                    commit    = 1'b1;
                    pass_init = 1'b1;
                    state_d   = S_RESET;
                end else begin
                    fin     = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            err_q     <= E_NONE;
            cmd_idx_q <= '0;
            tbit_q    <= 1'b0;
            chosen_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            chosen_q <= chosen_d;
            done_q   <= fin;
            if (search_init)
                cmd_idx_q <= '0;
            else if (state_q == S_CMD && slot_done)
                cmd_idx_q <= cmd_idx_q + 3'd1;
            if (state_q == S_RD_T && slot_done)
                tbit_q <= slot_rbit;
            if (search_init)
                err_q <= E_NONE;
            else if (fin)
                err_q <= err_d;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        slot_req  = busy;
        done      = done_q;
        err_code  = err_q;
        slot_wbit = 1'b0;
        slot_op   = OP_RESET;
        unique case (state_q)
            S_IDLE, S_RESET: slot_op = OP_RESET;
            S_CMD: begin
                slot_op   = OP_WRITE;
                slot_wbit = CMD_CODE[cmd_idx_q];
            end
            S_RD_T, S_RD_C: slot_op = OP_READ;
            S_WRITE: begin
                slot_op   = OP_WRITE;
                slot_wbit = chosen_q;
            end
            default: slot_op = OP_RESET;
        endcase
    end

    a_r1_pass_opens_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> slot_op == OP_RESET);
    a_r4_differ_writes_true: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_C && slot_done && (tbit_q != slot_rbit)) |=> (slot_wbit == $past(tbit_q)));
    a_r5_both_ones_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_C && slot_done && tbit_q && slot_rbit) |=> (done && err_code == E_BOTH_ONES));
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !slot_done) |=> busy);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/ow_srch_walker_tb.sv
`timescale 1ns/1ps
module ow_srch_walker_tb;
    localparam int MAXN = 4;
    localparam int PW   = 32;
    localparam int CW   = $clog2(MAXN + 1);
    localparam int AW   = $clog2(MAXN * 8);
    localparam logic [7:0] CMD = 8'hF0;

    // vector table: device count, seed, expected count, expected error
    localparam int NV = 5;
    localparam int V_NDEV [NV] = '{0, 1, 3, 4, 6};
    localparam int V_SEED [NV] = '{1, 11, 23, 37, 51};
    localparam int V_CNT  [NV] = '{0, 1, 3, 4, 4};
    localparam int V_ERR  [NV] = '{1, 0, 0, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, slot_req, slot_wbit, id_we;
    logic slot_done = 1'b0;
    logic slot_rbit = 1'b0;
    logic [1:0] err_code, slot_op;
    logic [CW-1:0] found_count;
    logic [AW-1:0] id_addr;
    logic [7:0] id_wdata;

    always #2.5 clk = ~clk;

    ow_srch_walker #(.MAX_IDS(MAXN), .PATH_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .err_code(err_code), .found_count(found_count), .slot_req(slot_req),
        .slot_op(slot_op), .slot_wbit(slot_wbit), .slot_done(slot_done),
        .slot_rbit(slot_rbit), .id_we(id_we), .id_addr(id_addr), .id_wdata(id_wdata)
    );

    // bus model state
    logic [63:0] dev [0:39];
    bit          act [0:39];
    int ndev = 0, ph = 0, sub = 0, bitk = 0, fault_bit = -1;
    int proto_err = 0, resets = 0;
    logic [7:0] mem [0:MAXN*8-1];
    int checks = 0, errors = 0;
    int got_err, got_cnt;

    task automatic check(input bit ok, input string req, input string what,
                         input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, actv, expv);
        end
    endtask

    function automatic logic [63:0] gen_id(input int s);
        logic [63:0] x;
        x = 64'h9E3779B97F4A7C15 * 64'(s + 1);
        x = x ^ (x >> 29);
        x = x * 64'hBF58476D1CE4E5B9;
        x = x ^ (x >> 32);
        return x;
    endfunction

    function automatic logic [63:0] rev64(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[63-i];
        return r;
    endfunction

    task automatic serve(input logic [1:0] op, input logic wb);
        logic v;
        case (op)
            2'd0: begin
                resets++; ph = 0; sub = 0; bitk = 0;
                for (int i = 0; i < 40; i++) act[i] = 1'b1;
                slot_rbit = (ndev > 0);
            end
            2'd1: begin
                if (ph < 8) begin
                    if (wb != CMD[ph]) proto_err++;
                    ph++;
                end else begin
                    if (sub != 2 || bitk > 63) proto_err++;
                    else begin
                        for (int i = 0; i < ndev; i++)
                            if (act[i] && dev[i][bitk] != wb) act[i] = 1'b0;
                        bitk++;
                    end
                    sub = 0;
                end
            end
            2'd2: begin
                if (ph < 8 || sub == 2 || bitk > 63) proto_err++;
                else begin
                    v = 1'b1;
                    for (int i = 0; i < ndev; i++)
                        if (act[i]) v = v & (sub == 0 ? dev[i][bitk] : ~dev[i][bitk]);
                    if (bitk == fault_bit) v = 1'b1;
                    slot_rbit = v;
                    sub++;
                end
            end
            default: proto_err++;
        endcase
    endtask

    // slot engine model
    initial begin
        logic [1:0] op;
        logic wb;
        forever begin
            @(negedge clk);
            slot_done = 1'b0;
            if (rst_n && slot_req) begin
                op = slot_op;
                wb = slot_wbit;
                repeat (2) @(negedge clk);
                serve(op, wb);
                slot_done = 1'b1;
            end
        end
    end

    // identifier memory capture
    always @(negedge clk) if (id_we) mem[id_addr] <= id_wdata;

    task automatic clear_run();
        for (int i = 0; i < MAXN * 8; i++) mem[i] = 8'h00;
        proto_err = 0;
        resets = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        got_err = int'(err_code);
        got_cnt = int'(found_count);
        @(negedge clk);
        check(done == 1'b0, "R11", "done lasts one cycle", longint'(done), 0);
        @(negedge clk);
    endtask

    task automatic check_ids(input int n);
        logic [63:0] id, prev;
        bit member, dup;
        prev = '0;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) id[8*b +: 8] = mem[8*k + b];
            member = 1'b0;
            for (int j = 0; j < ndev; j++) if (dev[j] == id) member = 1'b1;
            check(member, "R7", "stored id is a bus device", longint'(id), 0);
            dup = 1'b0;
            for (int m = 0; m < k; m++) begin
                logic [63:0] o;
                for (int b = 0; b < 8; b++) o[8*b +: 8] = mem[8*m + b];
                if (o == id) dup = 1'b1;
            end
            check(!dup, "R6", "id found twice", longint'(id), 0);
            if (k > 0)
                check(rev64(id) > rev64(prev), "R6", "bit-reversed order", longint'(rev64(id)), longint'(rev64(prev)));
            prev = id;
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check(busy == 1'b0 && done == 1'b0, "R11", "busy/done after reset", longint'({busy, done}), 0);
        check(slot_req == 1'b0 && id_we == 1'b0, "R11", "req/we after reset", longint'({slot_req, id_we}), 0);
        check(found_count == '0, "R11", "count after reset", longint'(found_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of device populations
        for (int v = 0; v < NV; v++) begin
            ndev = V_NDEV[v];
            fault_bit = -1;
            for (int i = 0; i < ndev; i++) dev[i] = gen_id(V_SEED[v] * 7 + i);
            clear_run();
            pulse_start();
            wait_done();
            check(got_err == V_ERR[v], (V_ERR[v] == 1) ? "R1" : "R8", "error code", got_err, V_ERR[v]);
            check(got_cnt == V_CNT[v], "R8", "found count", got_cnt, V_CNT[v]);
            check(proto_err == 0, "R2", "command and R3 slot order", proto_err, 0);
            check(resets == ((V_CNT[v] == 0) ? 1 : V_CNT[v]), "R1", "one reset per pass", resets, V_CNT[v]);
            check_ids(got_cnt);
        end

        // R5: both reads return 1
        ndev = 2; dev[0] = gen_id(200); dev[1] = gen_id(201); fault_bit = 5;
        clear_run(); pulse_start(); wait_done();
        check(got_err == 2, "R5", "both ones error", got_err, 2);
        check(got_cnt == 0, "R5", "no id stored", got_cnt, 0);
        fault_bit = -1;

        // R9: discrepancy chain longer than the mask
        ndev = 34; dev[0] = '0;
        for (int j = 0; j < 33; j++) dev[j+1] = 64'(1) << j;
        clear_run(); pulse_start(); wait_done();
        check(got_err == 3, "R9", "mask exhausted error", got_err, 3);
        check(got_cnt == 0, "R9", "no id stored", got_cnt, 0);

        // R4 / R6: devices that differ only in the last bit
        ndev = 2; dev[0] = gen_id(300) & ~(64'(1) << 63); dev[1] = dev[0] | (64'(1) << 63);
        clear_run(); pulse_start(); wait_done();
        check(got_cnt == 2 && got_err == 0, "R6", "last-bit branch both found", got_cnt, 2);
        check(resets == 2, "R6", "two passes", resets, 2);
        check({mem[7], mem[6], mem[5], mem[4], mem[3], mem[2], mem[1], mem[0]} == dev[0],
              "R4", "first pass takes 0 side", longint'({mem[7], mem[6], mem[5], mem[4]}), longint'(dev[0][63:32]));
        check(mem[0] == dev[0][7:0], "R7", "byte 0 holds bits 7..0", mem[0], dev[0][7:0]);
        check(proto_err == 0, "R3", "slot order", proto_err, 0);

        // R10: start while busy is ignored
        ndev = 3;
        for (int i = 0; i < 3; i++) dev[i] = gen_id(400 + i);
        clear_run(); pulse_start();
        repeat (300) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        check(resets == 3, "R10", "no extra reset slot", resets, 3);
        check(got_cnt == 3 && got_err == 0, "R10", "count kept", got_cnt, 3);
        check_ids(got_cnt);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule